// File: doc/BRIEF.md
# Coincident-Current Core Memory Sequencer

This block runs the access cycle of a magnetic core array whose planes are modelled in logic outside it. A host asks for one word by raising a request with an address, a direction flag and, for stores, the data. The sequencer then turns on exactly one X select line and one Y select line. The core that sits where the two lines cross is the only one driven hard enough to switch.

Every access has the same two halves. In the first half, current is driven in the clearing direction. This forces every bit of the chosen word to 0. Any bit that held a 1 answers with a pulse on its sense input, and those pulses are collected into a captured word. A short gap follows while the captured word settles. In the second half, current is driven in the setting direction. Each bit that has to end up 0 is held back by its inhibit strobe, and each bit that has to end up 1 is left free to flip. For a host read, the second half writes the captured word back. For a host write, it stores the host data instead.

The host sees busy for the whole access. It then sees a single-cycle done, together with the restored read data.

Top module: `ccm_ctrl`

## Requirements
- R1: After reset, and whenever busy is low, no X or Y line is active, the set-direction flag is low, every inhibit strobe is low, done is low and busy is low.
- R2: While current is driven, exactly one X line and exactly one Y line are active. The X line number is address bits [1:0] and the Y line number is address bits [3:2]. No line is active outside a drive phase.
- R3: An accepted request is followed by DRIVE_CYC cycles of clearing drive (set flag low), then one cycle with no drive, then DRIVE_CYC cycles of setting drive (set flag high), then one done cycle. Busy is high for all 2*DRIVE_CYC+2 of these cycles, and it is low in the cycle after.
- R4: Every inhibit strobe is low during the clearing drive.
- R5: From the gap cycle through the done cycle, inhibit bit i is high exactly when bit i of the word being stored is 0. Its value does not change over that span.
- R6: The captured word is the bitwise OR of all sense pulses seen during the clearing drive. A host read stores that word back into the array and returns it on read data.
- R7: A host write stores the host data at the addressed word and leaves read data unchanged.
- R8: Done is high for exactly one cycle, the cycle after the setting drive ends. Read data takes its new value in that same cycle and not before.
- R9: A request raised while busy is high is ignored. No second access follows, and no other word of the array is touched.
- R10: Sense pulses outside the clearing drive have no effect on the captured word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_req | input | 1 | Access request, sampled while idle |
| host_wr | input | 1 | 1 = store host_wdata, 0 = read |
| host_addr | input | 4 | Word address, bits [1:0] pick X and bits [3:2] pick Y |
| host_wdata | input | 8 | Data for a host write |
| host_busy | output | 1 | Access in progress |
| host_done | output | 1 | One-cycle completion pulse |
| host_rdata | output | 8 | Word returned by the last host read |
| core_x | output | 4 | One-hot X select drive |
| core_y | output | 4 | One-hot Y select drive |
| core_set | output | 1 | Drive direction: 1 = setting, 0 = clearing |
| core_inh | output | 8 | Per-bit inhibit strobes |
| core_sense | input | 8 | Per-bit sense pulses from the array |

## Verification
A sequencer stuck in the wrong phase or holding a stale count shows up at the array pins within the same access. The drive appears with the wrong polarity, in the wrong cycle or for the wrong length, or it overlaps a non-zero inhibit. A fault in the capture or inhibit path reaches the ports more slowly. It is visible only as a changed word in the modelled array, or as wrong read data on the next read of that address. So every read is compared with a shadow copy kept by the bench, and the array word is compared right after each access.

// File: rtl/ccm_pkg.sv
package ccm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_DRIVE,
        ST_SENSE,
        ST_WR_DRIVE,
        ST_DONE
    } ccm_state_e;

endpackage

// File: rtl/ccm_line_dec.sv
module ccm_line_dec #(
    parameter int LINES = 4,
    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic             en,
    input  logic [IDX_W-1:0] idx,
    output logic [LINES-1:0] lines
);

    for (genvar i = 0; i < LINES; i++) begin : g_line
        assign lines[i] = en && (idx == IDX_W'(i));
    end

endmodule

// File: rtl/ccm_sense_latch.sv
module ccm_sense_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         cap_en,
    input  logic [W-1:0] sense,
    output logic [W-1:0] word
);

    logic [W-1:0] word_d, word_q;

    always_comb begin
        word_d = word_q;
        if (clr) begin
            word_d = '0;
        end else if (cap_en) begin
            word_d = word_q | sense;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else begin
            word_q <= word_d;
        end
    end

    assign word = word_q;

endmodule

// File: rtl/ccm_ctrl.sv
module ccm_ctrl
    import ccm_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int X_LINES   = 4,
    parameter int Y_LINES   = 4,
    parameter int DRIVE_CYC = 3,
    localparam int XA_W   = $clog2(X_LINES),
    localparam int YA_W   = $clog2(Y_LINES),
    localparam int ADDR_W = XA_W + YA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_busy,
    output logic              host_done,
    output logic [DATA_W-1:0] host_rdata,
    output logic [X_LINES-1:0] core_x,
    output logic [Y_LINES-1:0] core_y,
    output logic              core_set,
    output logic [DATA_W-1:0] core_inh,
    input  logic [DATA_W-1:0] core_sense
);

    localparam int CNT_W = $clog2(DRIVE_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(DRIVE_CYC - 1);

    typedef struct packed {
        ccm_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic              is_wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wword;
        logic [DATA_W-1:0] rdata;
    } regs_t;

    regs_t r_d, r_q;
    logic  cap_clr;
    logic  drive_en;
    logic  inh_window;
    logic [DATA_W-1:0] cap_word;
    logic [DATA_W-1:0] target;

    // Next-state computation
    always_comb begin
        r_d     = r_q;
        cap_clr = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (host_req) begin
                    r_d.st    = ST_RD_DRIVE;
                    r_d.cnt   = CNT_LOAD;
                    r_d.is_wr = host_wr;
                    r_d.addr  = host_addr;
                    r_d.wword = host_wdata;
                    cap_clr   = 1'b1;
                end
            end
            ST_RD_DRIVE: begin
                if (r_q.cnt == '0) begin
                    r_d.st = ST_SENSE;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_SENSE: begin
                r_d.st  = ST_WR_DRIVE;
                r_d.cnt = CNT_LOAD;
            end
            ST_WR_DRIVE: begin
                if (r_q.cnt == '0) begin
                    r_d.st = ST_DONE;
                    if (!r_q.is_wr) begin
                        r_d.rdata = cap_word;
                    end
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_DONE: begin
                r_d.st = ST_IDLE;
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, cnt: '0, is_wr: 1'b0, addr: '0,
                     wword: '0, rdata: '0};
        end else begin
            r_q <= r_d;
        end
    end

    // Sense capture during the clearing drive only
    ccm_sense_latch #(.W(DATA_W)) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (cap_clr),
        .cap_en (r_q.st == ST_RD_DRIVE),
        .sense  (core_sense),
        .word   (cap_word)
    );

    assign drive_en = (r_q.st == ST_RD_DRIVE) || (r_q.st == ST_WR_DRIVE);

    ccm_line_dec #(.LINES(X_LINES)) u_xdec (
        .en    (drive_en),
        .idx   (r_q.addr[XA_W-1:0]),
        .lines (core_x)
    );

    ccm_line_dec #(.LINES(Y_LINES)) u_ydec (
        .en    (drive_en),
        .idx   (r_q.addr[ADDR_W-1:XA_W]),
        .lines (core_y)
    );

    // Inhibit window spans one cycle either side of the setting drive
    assign inh_window = (r_q.st == ST_SENSE) || (r_q.st == ST_WR_DRIVE) ||
                        (r_q.st == ST_DONE);
    assign target     = r_q.is_wr ? r_q.wword : cap_word;
    assign core_inh   = inh_window ? ~target : '0;
    assign core_set   = (r_q.st == ST_WR_DRIVE);

    assign host_busy  = (r_q.st != ST_IDLE);
    assign host_done  = (r_q.st == ST_DONE);
    assign host_rdata = r_q.rdata;

endmodule

// File: rtl/ccm_ctrl_chk.sv
module ccm_ctrl_chk #(
    parameter int DATA_W    = 8,
    parameter int X_LINES   = 4,
    parameter int Y_LINES   = 4,
    parameter int DRIVE_CYC = 3,
    localparam int ADDR_W = $clog2(X_LINES) + $clog2(Y_LINES)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               host_req,
    input logic               host_wr,
    input logic [ADDR_W-1:0]  host_addr,
    input logic [DATA_W-1:0]  host_wdata,
    input logic               host_busy,
    input logic               host_done,
    input logic [DATA_W-1:0]  host_rdata,
    input logic [X_LINES-1:0] core_x,
    input logic [Y_LINES-1:0] core_y,
    input logic               core_set,
    input logic [DATA_W-1:0]  core_inh,
    input logic [DATA_W-1:0]  core_sense
);

    // R2
    drive_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|core_x || |core_y) |-> ($countones(core_x) == 1 && $countones(core_y) == 1));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !host_busy |-> (core_x == '0 && core_y == '0 && !core_set && core_inh == '0 && !host_done));

    // R4
    clear_no_inh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|core_x && !core_set) |-> core_inh == '0);

    // R5
    inh_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_set) |-> $stable(core_inh));

    // R5
    inh_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_set) |-> ($stable(core_inh) && core_x == '0));

    // R3
    set_after_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_set) |-> ($past(core_x) == '0 && host_busy));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_done |=> !host_done);

    // R8
    done_after_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_set) |-> host_done);

endmodule

bind ccm_ctrl ccm_ctrl_chk #(
    .DATA_W    (DATA_W),
    .X_LINES   (X_LINES),
    .Y_LINES   (Y_LINES),
    .DRIVE_CYC (DRIVE_CYC)
) u_chk (.*);

// File: tb/ccm_ctrl_test.sv
`timescale 1ns/1ps
module ccm_ctrl_test;

    localparam int DW = 8;
    localparam int D  = 3;
    localparam int NW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_req = 1'b0;
    logic          host_wr = 1'b0;
    logic [3:0]    host_addr = '0;
    logic [DW-1:0] host_wdata = '0;
    logic          host_busy, host_done;
    logic [DW-1:0] host_rdata;
    logic [3:0]    core_x, core_y;
    logic          core_set;
    logic [DW-1:0] core_inh;
    logic [DW-1:0] core_sense;
    logic [DW-1:0] sense_inj = '0;

    int checks = 0;
    int errors = 0;

    logic [DW-1:0] arr    [NW];
    logic [DW-1:0] shadow [NW];
    logic [DW-1:0] exp_rdata = '0;

    always #4 clk = ~clk;

    ccm_ctrl #(.DATA_W(DW), .X_LINES(4), .Y_LINES(4), .DRIVE_CYC(D)) uut (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_busy(host_busy),
        .host_done(host_done), .host_rdata(host_rdata), .core_x(core_x),
        .core_y(core_y), .core_set(core_set), .core_inh(core_inh),
        .core_sense(core_sense)
    );

    // Behavioural core array: clearing drive empties the word and echoes ones
    // on sense; setting drive turns on every bit whose inhibit is low.
    logic [3:0] sel;
    logic       sel_ok;
    always_comb begin
        sel = '0;
        sel_ok = (core_x != '0) && (core_y != '0);
        for (int i = 0; i < 4; i++) begin
            if (core_x[i]) sel[1:0] = 2'(i);
            if (core_y[i]) sel[3:2] = 2'(i);
        end
        core_sense = ((sel_ok && !core_set) ? arr[sel] : '0) | sense_inj;
    end

    always @(posedge clk) begin
        if (sel_ok) begin
            if (!core_set) arr[sel] <= '0;
            else           arr[sel] <= arr[sel] | ~core_inh;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One access with per-cycle port checks.
    // inj_cyc: cycle (1-based after accept) in which sense_inj carries inj_val.
    // busy_req: raise a stray request in cycle 2.
    task automatic do_op(input bit wr, input logic [3:0] a, input logic [DW-1:0] wd,
                         input int inj_cyc, input logic [DW-1:0] inj_val,
                         input bit busy_req);
        logic [DW-1:0] tgt;
        logic [DW-1:0] old_rdata;
        logic [3:0]    exp_x, exp_y;
        bit seq_ok, drv_ok, inh_clr_ok, inh_ok, done_ok, rd_early_ok;
        seq_ok = 1; drv_ok = 1; inh_clr_ok = 1; inh_ok = 1; done_ok = 1; rd_early_ok = 1;
        old_rdata = exp_rdata;
        tgt = wr ? wd : (shadow[a] | ((inj_cyc >= 1 && inj_cyc <= D) ? inj_val : '0));
        exp_x = 4'(1 << a[1:0]);
        exp_y = 4'(1 << a[3:2]);
        @(negedge clk);
        host_req = 1'b1; host_wr = wr; host_addr = a; host_wdata = wd;
        @(negedge clk);
        host_req = 1'b0;
        for (int c = 1; c <= 2*D+2; c++) begin
            bit rd, gap, wp, dn;
            rd = (c <= D); gap = (c == D+1); wp = (c >= D+2 && c <= 2*D+1); dn = (c == 2*D+2);
            if (!host_busy) seq_ok = 0;
            if (core_set !== wp) seq_ok = 0;
            if ((rd || wp) && (core_x !== exp_x || core_y !== exp_y)) drv_ok = 0;
            if (!(rd || wp) && (core_x !== '0 || core_y !== '0)) drv_ok = 0;
            if (rd && core_inh !== '0) inh_clr_ok = 0;
            if ((gap || wp || dn) && core_inh !== ~tgt) inh_ok = 0;
            if (host_done !== dn) done_ok = 0;
            if (!dn && host_rdata !== old_rdata) rd_early_ok = 0;
            sense_inj = (c == inj_cyc) ? inj_val : '0;
            if (busy_req) begin
                if (c == 2) begin
                    host_req = 1'b1; host_wr = 1'b1; host_addr = a ^ 4'h5; host_wdata = 8'h99;
                end else begin
                    host_req = 1'b0;
                end
            end
            @(negedge clk);
        end
        sense_inj = '0;
        host_req = 1'b0;
        if (host_busy) seq_ok = 0;
        shadow[a] = tgt;
        if (!wr) exp_rdata = tgt;
        chk(seq_ok, "R3", "phase sequence/busy", {31'd0, seq_ok}, 32'd1);
        chk(drv_ok, "R2", "X/Y line selection", {31'd0, drv_ok}, 32'd1);
        chk(inh_clr_ok, "R4", "inhibit during clearing", {31'd0, inh_clr_ok}, 32'd1);
        chk(inh_ok, "R5", "inhibit window", {31'd0, inh_ok}, 32'd1);
        chk(done_ok, "R8", "done pulse", {31'd0, done_ok}, 32'd1);
        chk(rd_early_ok, "R8", "read data before done", {31'd0, rd_early_ok}, 32'd1);
        chk(arr[a] === tgt, wr ? "R7" : "R6", "array word after access", 32'(arr[a]), 32'(tgt));
        chk(host_rdata === exp_rdata, wr ? "R7" : "R6", "read data", 32'(host_rdata), 32'(exp_rdata));
    endtask

    // {write flag, address, data}
    localparam logic [12:0] VEC [8] = '{
        {1'b0, 4'd3,  8'h00},
        {1'b1, 4'd3,  8'hA5},
        {1'b0, 4'd3,  8'h00},
        {1'b1, 4'd15, 8'hFF},
        {1'b0, 4'd15, 8'h00},
        {1'b1, 4'd0,  8'h00},
        {1'b0, 4'd0,  8'h00},
        {1'b0, 4'd9,  8'h00}
    };

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < NW; i++) begin
            arr[i]    = 8'(i * 37 + 5);
            shadow[i] = 8'(i * 37 + 5);
        end
        repeat (3) @(negedge clk);
        // R1 reset state while in reset
        chk(!host_busy && !host_done && core_x == '0 && core_y == '0 && !core_set && core_inh == '0,
            "R1", "outputs in reset", {host_busy, host_done, core_set}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!host_busy && core_x == '0 && core_inh == '0 && host_rdata == '0,
            "R1", "outputs after reset", 32'(host_rdata), 32'd0);

        // Vector table: main function, reads restore, writes store
        for (int v = 0; v < 8; v++) begin
            do_op(VEC[v][12], VEC[v][11:8], VEC[v][7:0], 0, '0, 1'b0);
        end

        // R7: write leaves read data alone
        do_op(1'b1, 4'd9, 8'h3C, 0, '0, 1'b0);
        do_op(1'b0, 4'd9, 8'h00, 0, '0, 1'b0);

        // R6: an extra sense pulse in the second clearing cycle joins the captured word
        do_op(1'b1, 4'd6, 8'h40, 0, '0, 1'b0);
        do_op(1'b0, 4'd6, 8'h00, 2, 8'h01, 1'b0);
        chk(host_rdata === 8'h41, "R6", "OR of sense pulses", 32'(host_rdata), 32'h41);

        // R10: pulses in the gap cycle and in the setting drive are ignored
        do_op(1'b1, 4'd5, 8'h00, 0, '0, 1'b0);
        do_op(1'b0, 4'd5, 8'h00, D+1, 8'h80, 1'b0);
        chk(host_rdata === 8'h00, "R10", "gap sense ignored", 32'(host_rdata), 32'h00);
        do_op(1'b0, 4'd5, 8'h00, D+3, 8'h22, 1'b0);
        chk(host_rdata === 8'h00 && arr[5] === 8'h00, "R10", "setting-phase sense ignored",
            32'(arr[5]), 32'h00);

        // R9: stray request while busy
        do_op(1'b0, 4'd10, 8'h00, 0, '0, 1'b1);
        chk(!host_busy, "R9", "no second access", {31'd0, host_busy}, 32'd0);
        @(negedge clk);
        chk(!host_busy && core_x == '0, "R9", "still idle", {31'd0, host_busy}, 32'd0);
        chk(arr[10 ^ 5] === shadow[10 ^ 5], "R9", "other word untouched",
            32'(arr[10 ^ 5]), 32'(shadow[10 ^ 5]));

        // Full sweep: every word read back against the shadow copy
        for (int a = 0; a < NW; a++) begin
            do_op(1'b0, 4'(a), 8'h00, 0, '0, 1'b0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule